// File: doc/BRIEF.md
# Nibble-Parallel Frame-Slave Transmit Interface

This block sits in front of a DS3-style transmit framer. It takes payload from upstream equipment as 4-bit nibbles and turns it into one serial bit stream, timed by a local bit clock that runs at four times the nominal nibble rate. The block drives a one-cycle nibble strobe toward the upstream side. The upstream equipment must present a nibble in the cycle where the strobe is high, and the block takes it on that clock edge. The nibble is then shifted out most significant bit first.

Each frame holds a fixed number of nibbles. Fourteen of the nibble intervals in a frame last five bit clocks instead of four. The extra slot in each of those intervals carries an overhead bit that the block generates itself, taken from a parameter pattern. The spacing of these long intervals is even and comes from a table built at elaboration. The frame length is therefore 4 × nibbles + 14 bit clocks.

Frame timing follows the upstream side. The upstream equipment raises a frame reference with the first nibble of a frame. The block restarts its frame count on the rising edge of that reference, at any point in the frame. Until the first reference arrives, the strobe runs at a plain four-clock cadence and the output is marked invalid. An overhead-indicate input is present for pin compatibility only and has no effect.

The output stream has no ready signal. Once valid, it produces one bit in every cycle, and the consumer must accept every bit while `dout_valid` is high. On the input side, the nibble strobe is the only flow control: nothing stalls the block.

Top module: `nibtx_frame_slave`

## Requirements
- R1: Before the first frame reference after reset, `nib_clk` is a one-cycle pulse every 4 clocks, and `dout_valid` and `dout_sof` stay low, including during reset.
- R2: Once framed, the interval that follows nibble index i (counting from 0 at frame start) lasts 5 clocks when (i+1) is a multiple of SPACING = NIB_PER_FRAME/STRETCH_CNT and (i+1)/SPACING ≤ STRETCH_CNT. Every other interval lasts 4 clocks. With the defaults (28 nibbles, 14 long intervals) the odd indices are long and a frame is 126 clocks.
- R3: The nibble on `nib_in` at the clock edge where `nib_clk` is high is output on `dout` in the next four cycles, bit 3 first and bit 0 last.
- R4: The fifth cycle of the k-th long interval in a frame (k from 0) carries bit k of OH_PATTERN on `dout`.
- R5: A rising edge of `frame_ref` at any clock edge restarts the frame. The nibble on `nib_in` at that edge becomes nibble 0, and bits of an earlier nibble that have not yet been sent are dropped. The next `nib_clk` pulse comes 4 clocks later.
- R6: Holding `frame_ref` high for several cycles causes exactly one restart.
- R7: `dout_sof` is high for exactly one cycle, together with the first bit (bit 3 of nibble 0) of each frame. This includes frames that begin without a new reference.
- R8: `oh_ind` has no effect on any output.
- R9: From the cycle after the first restart, `dout_valid` is high in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| oh_ind | input | 1 | Overhead-indicate, tied low, ignored |
| frame_ref | input | 1 | Frame reference from upstream; a rising edge starts a frame |
| nib_in | input | 4 | Payload nibble, taken when nib_clk is high |
| nib_clk | output | 1 | One-cycle nibble strobe toward upstream |
| dout | output | 1 | Serial output bit |
| dout_valid | output | 1 | dout carries a framed bit |
| dout_sof | output | 1 | First bit of a frame |

## Verification
Two pairs of events can fall in the same cycle. The first is a frame restart and an ordinary nibble capture: the bench raises the reference coincident with a strobe and checks that the stream stays seamless. The second is a restart in the middle of an interval while a nibble is still being shifted out: the bench raises the reference two cycles after a strobe. The scoreboard then expects only the first two bits of the interrupted nibble, followed at once by the new frame's nibble 0 flagged as start of frame. The interval after the restart is measured to confirm that frame numbering has gone back to nibble 0.

// File: rtl/nibtx_pkg.sv
package nibtx_pkg;

  // True when the interval after nibble idx is a long one
  function automatic bit is_stretch(int idx, int spacing, int count);
    return (((idx + 1) % spacing) == 0) && (((idx + 1) / spacing) <= count);
  endfunction

endpackage

// File: rtl/nibtx_ref_edge.sv
module nibtx_ref_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_ref,
  output logic rise
);
  logic ref_q;

  always_ff @(posedge clk) begin
    if (!rst_n) ref_q <= 1'b0;
    else        ref_q <= frame_ref;
  end

  assign rise = frame_ref & ~ref_q;

  // R6
  single_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);

endmodule

// File: rtl/nibtx_timing.sv
module nibtx_timing #(
  parameter int NIBBLE_BITS   = 4,
  parameter int NIB_PER_FRAME = 28,
  parameter int STRETCH_CNT   = 14,
  localparam int SPACING      = NIB_PER_FRAME / STRETCH_CNT,
  localparam int IDX_W        = $clog2(NIB_PER_FRAME),
  localparam int OH_W         = $clog2(STRETCH_CNT),
  localparam int SLOT_W       = $clog2(NIBBLE_BITS + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            restart,
  output logic            nib_clk,
  output logic            capture,
  output logic            oh_slot,
  output logic            frame_first,
  output logic            synced,
  output logic [OH_W-1:0] oh_idx
);
  localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(NIBBLE_BITS - 1);
  localparam logic [SLOT_W-1:0] SLOT_OH   = SLOT_W'(NIBBLE_BITS);
  localparam logic [IDX_W-1:0]  IDX_LAST  = IDX_W'(NIB_PER_FRAME - 1);

  logic [SLOT_W-1:0]        slot;
  logic [IDX_W-1:0]         nib_idx;
  logic [NIB_PER_FRAME-1:0] stretch_map;
  logic                     long_int, at_end, frame_wrap;

  for (genvar g = 0; g < NIB_PER_FRAME; g++) begin : g_map
    assign stretch_map[g] = nibtx_pkg::is_stretch(g, SPACING, STRETCH_CNT);
  end

  assign long_int   = synced & stretch_map[nib_idx];
  assign at_end     = (slot == (long_int ? SLOT_OH : SLOT_LAST));
  assign frame_wrap = at_end & (nib_idx == IDX_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      synced  <= 1'b0;
      slot    <= '0;
      nib_idx <= '0;
      oh_idx  <= '0;
    end else if (restart) begin
      synced  <= 1'b1;
      slot    <= SLOT_W'(1);
      nib_idx <= '0;
      oh_idx  <= '0;
    end else if (at_end) begin
      slot    <= '0;
      nib_idx <= (!synced || frame_wrap) ? '0 : nib_idx + 1'b1;
      if (slot == SLOT_OH) oh_idx <= frame_wrap ? '0 : oh_idx + 1'b1;
    end else begin
      slot <= slot + 1'b1;
    end
  end

  assign nib_clk     = (slot == '0);
  assign capture     = restart | nib_clk;
  assign oh_slot     = (slot == SLOT_OH);
  assign frame_first = restart | (nib_clk & synced & (nib_idx == '0));

  // R1
  nib_clk_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (nib_clk && !restart) |=> !nib_clk);

  // R2
  oh_only_framed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    oh_slot |-> synced);

endmodule

// File: rtl/nibtx_serializer.sv
module nibtx_serializer #(
  parameter int                   NIBBLE_BITS = 4,
  parameter int                   STRETCH_CNT = 14,
  parameter logic [STRETCH_CNT-1:0] OH_PATTERN = '0,
  localparam int                  OH_W        = $clog2(STRETCH_CNT)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   capture,
  input  logic                   oh_slot,
  input  logic                   frame_first,
  input  logic                   valid_next,
  input  logic [OH_W-1:0]        oh_idx,
  input  logic [NIBBLE_BITS-1:0] nib_in,
  output logic                   dout,
  output logic                   dout_valid,
  output logic                   dout_sof
);
  logic [NIBBLE_BITS-2:0] rest_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dout       <= 1'b0;
      dout_valid <= 1'b0;
      dout_sof   <= 1'b0;
      rest_q     <= '0;
    end else begin
      dout_valid <= valid_next;
      dout_sof   <= frame_first;
      if (capture) begin
        dout   <= nib_in[NIBBLE_BITS-1];
        rest_q <= nib_in[NIBBLE_BITS-2:0];
      end else if (oh_slot) begin
        dout <= OH_PATTERN[oh_idx];
      end else begin
        dout   <= rest_q[NIBBLE_BITS-2];
        rest_q <= rest_q << 1;
      end
    end
  end

  // R7
  sof_in_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dout_sof |-> dout_valid);

  // R9
  valid_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dout_valid |=> dout_valid);

endmodule

// File: rtl/nibtx_frame_slave.sv
module nibtx_frame_slave #(
  parameter int                     NIBBLE_BITS   = 4,
  parameter int                     NIB_PER_FRAME = 28,
  parameter int                     STRETCH_CNT   = 14,
  parameter logic [STRETCH_CNT-1:0] OH_PATTERN    = 14'h2CE5
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   oh_ind,
  input  logic                   frame_ref,
  input  logic [NIBBLE_BITS-1:0] nib_in,
  output logic                   nib_clk,
  output logic                   dout,
  output logic                   dout_valid,
  output logic                   dout_sof
);
  localparam int OH_W = $clog2(STRETCH_CNT);

  logic            restart, capture, oh_slot, frame_first, synced;
  logic [OH_W-1:0] oh_idx;
  logic            unused_oh_ind;

  assign unused_oh_ind = oh_ind;

  nibtx_ref_edge u_edge (
    .clk       (clk),
    .rst_n     (rst_n),
    .frame_ref (frame_ref),
    .rise      (restart)
  );

  nibtx_timing #(
    .NIBBLE_BITS   (NIBBLE_BITS),
    .NIB_PER_FRAME (NIB_PER_FRAME),
    .STRETCH_CNT   (STRETCH_CNT)
  ) u_timing (
    .clk         (clk),
    .rst_n       (rst_n),
    .restart     (restart),
    .nib_clk     (nib_clk),
    .capture     (capture),
    .oh_slot     (oh_slot),
    .frame_first (frame_first),
    .synced      (synced),
    .oh_idx      (oh_idx)
  );

  nibtx_serializer #(
    .NIBBLE_BITS (NIBBLE_BITS),
    .STRETCH_CNT (STRETCH_CNT),
    .OH_PATTERN  (OH_PATTERN)
  ) u_ser (
    .clk         (clk),
    .rst_n       (rst_n),
    .capture     (capture),
    .oh_slot     (oh_slot),
    .frame_first (frame_first),
    .valid_next  (synced | restart),
    .oh_idx      (oh_idx),
    .nib_in      (nib_in),
    .dout        (dout),
    .dout_valid  (dout_valid),
    .dout_sof    (dout_sof)
  );

  // R5
  ref_starts_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_ref && !$past(frame_ref)) |=> dout_sof);

  // R7
  sof_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dout_sof |=> !dout_sof);

endmodule

// File: tb/tb_nibtx_frame_slave.sv
`timescale 1ns/1ps
module tb_nibtx_frame_slave;
  localparam int          NIB = 28;
  localparam int          STR = 14;
  localparam int          SP  = NIB / STR;
  localparam logic [13:0] OHP = 14'h2CE5;

  logic       clk = 1'b0, rst_n = 1'b0, oh_ind = 1'b0, frame_ref = 1'b0;
  logic [3:0] nib_in = 4'h0;
  logic       nib_clk, dout, dout_valid, dout_sof;

  nibtx_frame_slave #(.NIBBLE_BITS(4), .NIB_PER_FRAME(NIB), .STRETCH_CNT(STR),
                      .OH_PATTERN(OHP)) dut (
    .clk(clk), .rst_n(rst_n), .oh_ind(oh_ind), .frame_ref(frame_ref),
    .nib_in(nib_in), .nib_clk(nib_clk), .dout(dout),
    .dout_valid(dout_valid), .dout_sof(dout_sof));

  always #2.5 clk = ~clk;

  typedef struct packed { logic b; logic s; } exp_t;
  exp_t q[$];
  int   n_tests = 0, n_fail = 0;
  bit   summary_done = 0, mon_on = 0, expect_valid = 0;

  function automatic bit stretched(int i);
    return (((i + 1) % SP) == 0) && (((i + 1) / SP) <= STR);
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!summary_done) begin
      summary_done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    end
    $finish;
  endtask

  // Monitor: pops expected bits and compares them with the stream
  always @(negedge clk) begin
    exp_t e;
    if (mon_on) begin
      if (expect_valid) check(dout_valid === 1'b1, "R9 valid", int'(dout_valid), 1);
      if (dout_valid) begin
        if (q.size() == 0) check(0, "R3 unexpected bit", 1, 0);
        else begin
          e = q.pop_front();
          check(dout === e.b, "R3/R4 data", int'(dout), int'(e.b));
          check(dout_sof === e.s, "R7 sof", int'(dout_sof), int'(e.s));
        end
      end else begin
        check(dout_sof === 1'b0, "R1 sof while invalid", int'(dout_sof), 0);
      end
    end
  end

  // Driver: feeds nibbles on strobes and pushes the expected stream
  task automatic send_frame(int base, bit use_ref, int hold, bit mid, bit ohi,
                            int n_nib, bit trunc);
    int k = 0;
    int hold_left = 0;
    for (int i = 0; i < n_nib; i++) begin
      logic [3:0] v;
      int gap = 0;
      v = 4'(base + i * 5 + i * i);
      if (i == 0 && mid) begin
        @(negedge clk);
        @(negedge clk);
      end else begin
        do begin
          @(negedge clk);
          gap++;
          if (hold_left > 0) begin
            hold_left--;
            if (hold_left == 0) frame_ref = 1'b0;
          end
          if (ohi) oh_ind = 1'($urandom_range(0, 1));
        end while (!nib_clk);
        if (i == 1 && use_ref)
          check(gap == 4, "R5 interval after restart", gap, 4);
        else if (i > 0)
          check(gap == (stretched(i - 1) ? 5 : 4), "R2 interval", gap,
                stretched(i - 1) ? 5 : 4);
        else if (!use_ref)
          check(gap == (stretched(NIB - 1) ? 5 : 4), "R2 wrap interval", gap,
                stretched(NIB - 1) ? 5 : 4);
      end
      if (i == 0 && use_ref) begin
        frame_ref = 1'b1;
        hold_left = hold;
        expect_valid <= 1'b1;
      end
      nib_in = v;
      if (trunc && i == n_nib - 1) begin
        q.push_back('{v[3], 1'b0});
        q.push_back('{v[2], 1'b0});
      end else begin
        for (int b = 3; b >= 0; b--) q.push_back('{v[b], (i == 0 && b == 3)});
        if (stretched(i)) begin
          q.push_back('{OHP[k], 1'b0});
          k++;
        end
      end
    end
  endtask

  initial begin
    #(200000 * 5);
    check(0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    int gap;
    // R1: reset state
    repeat (3) @(negedge clk);
    check(dout_valid === 1'b0, "R1 reset valid", int'(dout_valid), 0);
    check(dout_sof === 1'b0, "R1 reset sof", int'(dout_sof), 0);
    rst_n = 1'b1;
    mon_on = 1;
    // R1: free-running 4-clock cadence before framing
    do @(negedge clk); while (!nib_clk);
    for (int p = 0; p < 4; p++) begin
      gap = 0;
      do begin @(negedge clk); gap++; end while (!nib_clk);
      check(gap == 4, "R1 pre-frame cadence", gap, 4);
      check(dout_valid === 1'b0, "R1 pre-frame valid", int'(dout_valid), 0);
    end
    // Reference coincident with a strobe
    send_frame(3, 1, 1, 0, 0, NIB, 0);
    send_frame(9, 1, 1, 0, 0, NIB, 0);
    // R7: frame wrap with no new reference
    send_frame(6, 0, 0, 0, 0, NIB, 0);
    // R6 held reference, R8 overhead-indicate toggling
    send_frame(12, 1, 3, 0, 1, NIB, 0);
    oh_ind = 1'b0;
    // R5: restart in the middle of a nibble
    send_frame(1, 0, 0, 0, 0, 11, 1);
    send_frame(14, 1, 1, 1, 0, NIB, 0);
    send_frame(4, 1, 2, 0, 0, NIB, 0);
    wait (q.size() == 0);
    mon_on = 0;
    finish_run();
  end
endmodule